// File: doc/BRIEF.md
# Entropy Collector with Repeated-Group Health Test

This block takes a stream of conditioned random bits, one per cycle when the bit strobe is high. It collects them into a 192-bit holding register. Incoming bits are first assembled into 16-bit groups. Each finished group is compared against the group accepted or seen just before it. A match is treated as a stuck or repeating source: the error flag is set and the group is thrown away. The group that arrives after a failure is accepted without a comparison and becomes the new reference. A bypass input turns the comparison off.

When twelve groups have been stored, the full flag rises and collection pauses until software clears it. The holding register is read as six 32-bit words. The first accepted bit sits in bit 0 of word 0, and the last bit of a fill sits in bit 31 of word 5.

A counter reset request throws away the partial group, the group position and the full flag. It is honoured only while the source is disabled. The holding data itself is kept, as is the comparison reference.

Top module: `entropy_collector`

## Requirements
- R1: When the 192nd accepted bit of a fill is taken at a clock edge, `full_o` is 1 after that edge.
- R2: The n-th accepted bit of a fill (n counted from 0, excluding discarded groups) is stored at holding bit n. Word k of `words_o` carries holding bits 32k+31 down to 32k.
- R3: When a finished 16-bit group equals the previous reference group and the test is not bypassed, `rep_err_o` is 1 after that edge and the group is not stored.
- R4: After a failure the next finished group is stored without a comparison and becomes the reference.
- R5: While `test_byp_i` is 1 at group completion, no failure is raised and the group is stored and becomes the reference.
- R6: A `cnt_rst_i` pulse with `src_en_i` low clears `full_o`, the group position and any partial group. With `src_en_i` high it has no effect.
- R7: `clr_full_i` clears `full_o` and `clr_err_i` clears `rep_err_o`. A failure in the same cycle as `clr_err_i` leaves `rep_err_o` at 1.
- R8: `busy_o` equals `src_en_i` AND NOT `full_o`. Bits are taken only when `bit_vld_i`, `src_en_i` and NOT `full_o` are all true; other bits change nothing.
- R9: After reset, `words_o`, `full_o`, `rep_err_o` are all zero and no reference group is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_en_i | input | 1 | Entropy source enable |
| bit_vld_i | input | 1 | Strobe for bit_i |
| bit_i | input | 1 | Conditioned random bit |
| test_byp_i | input | 1 | Bypass the repeated-group test |
| cnt_rst_i | input | 1 | Counter reset request (honoured while source disabled) |
| clr_full_i | input | 1 | Clear the full flag |
| clr_err_i | input | 1 | Clear the test error flag |
| words_o | output | NUM_WORDS x WORD_W (6 x 32) | Holding register as words, word 0 lowest |
| full_o | output | 1 | All holding bits collected |
| busy_o | output | 1 | Source enabled and register not full |
| rep_err_o | output | 1 | Sticky repeated-group failure |

## Verification
The bench builds the block with its default parameters: 192 holding bits, 32-bit words and 16-bit groups. With these values a full fill takes 192 strobes, so complete fills, pauses while full and refills are all cheap. Repeating a 16-bit pattern on purpose triggers the health test, the discard of the failing group and the reference takeover that follows. A behavioural model built from bit queues is compared with every output on every clock. Directed checks cover word placement, clear priority and counter reset while the source is on and while it is off.

// File: rtl/ec_pkg.sv
package ec_pkg;
  typedef enum logic [1:0] {
    VERD_NONE = 2'd0,
    VERD_PASS = 2'd1,
    VERD_FAIL = 2'd2
  } verdict_e;
endpackage

// File: rtl/ec_group_packer.sv
module ec_group_packer #(
  parameter int GROUP_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               take_i,
  input  logic               bit_i,
  input  logic               flush_i,
  output logic               done_o,
  output logic [GROUP_W-1:0] grp_o
);
  localparam int CNT_W = $clog2(GROUP_W);

  logic [GROUP_W-1:0] grp_q;
  logic [CNT_W-1:0]   cnt_q;

  assign done_o = take_i && (cnt_q == CNT_W'(GROUP_W - 1));

  always_comb begin
    grp_o = grp_q;
    grp_o[GROUP_W-1] = bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_q <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      grp_q <= '0;
      cnt_q <= '0;
    end else if (take_i) begin
      grp_q[cnt_q] <= bit_i;
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
    end
  end

  p_group_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (cnt_q == '0));
  p_flush_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0));
endmodule

// File: rtl/ec_rep_tester.sv
module ec_rep_tester
  import ec_pkg::*;
#(
  parameter int GROUP_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               done_i,
  input  logic [GROUP_W-1:0] grp_i,
  input  logic               bypass_i,
  input  logic               clr_err_i,
  output verdict_e           verdict_o,
  output logic               err_o
);
  logic [GROUP_W-1:0] ref_q;
  logic               ref_vld_q;
  logic               err_q;

  always_comb begin
    verdict_o = VERD_NONE;
    if (done_i) begin
      if (!bypass_i && ref_vld_q && (grp_i == ref_q)) verdict_o = VERD_FAIL;
      else                                            verdict_o = VERD_PASS;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q     <= '0;
      ref_vld_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      unique case (verdict_o)
        VERD_FAIL: begin
          ref_vld_q <= 1'b0;   // next group becomes reference unchecked
          err_q     <= 1'b1;
        end
        VERD_PASS: begin
          ref_q     <= grp_i;
          ref_vld_q <= 1'b1;
          if (clr_err_i) err_q <= 1'b0;
        end
        default: if (clr_err_i) err_q <= 1'b0;
      endcase
    end
  end

  assign err_o = err_q;

  p_fail_sets_err_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_o == VERD_FAIL) |=> err_q);
  p_fail_drops_ref_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (verdict_o == VERD_FAIL) |=> !ref_vld_q);
  p_bypass_no_fail_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |-> (verdict_o != VERD_FAIL));
  p_clear_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_err_i && !done_i) |=> !err_q);
endmodule

// File: rtl/ec_hold_reg.sv
module ec_hold_reg #(
  parameter int HOLD_W  = 192,
  parameter int GROUP_W = 16,
  parameter int WORD_W  = 32
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   store_i,
  input  logic [GROUP_W-1:0]                     grp_i,
  input  logic                                   flush_i,
  input  logic                                   clr_full_i,
  output logic [HOLD_W/WORD_W-1:0][WORD_W-1:0]   words_o,
  output logic                                   full_o
);
  localparam int NUM_GROUPS = HOLD_W / GROUP_W;
  localparam int NUM_WORDS  = HOLD_W / WORD_W;
  localparam int SLOT_W     = $clog2(NUM_GROUPS);

  logic [HOLD_W-1:0] hold_q;
  logic [SLOT_W-1:0] slot_q;
  logic              full_q;
  logic              last_slot;

  assign last_slot = (slot_q == SLOT_W'(NUM_GROUPS - 1));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    hold_q[g*GROUP_W +: GROUP_W] <= '0;
      else if (store_i && slot_q == SLOT_W'(g))       hold_q[g*GROUP_W +: GROUP_W] <= grp_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      full_q <= 1'b0;
    end else if (flush_i) begin
      slot_q <= '0;
      full_q <= 1'b0;
    end else if (store_i) begin
      slot_q <= last_slot ? '0 : slot_q + 1'b1;
      if (last_slot) full_q <= 1'b1;
    end else if (clr_full_i) begin
      full_q <= 1'b0;
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign words_o[w] = hold_q[w*WORD_W +: WORD_W];
  end

  assign full_o = full_q;

  p_no_store_when_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |-> !store_i);
  p_full_after_last_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && last_slot && !flush_i) |=> full_q);
  p_full_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !clr_full_i && !flush_i) |=> (full_q && $stable(hold_q)));
endmodule

// File: rtl/entropy_collector.sv
module entropy_collector
  import ec_pkg::*;
#(
  parameter int HOLD_W  = 192,
  parameter int GROUP_W = 16,
  parameter int WORD_W  = 32
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 src_en_i,
  input  logic                                 bit_vld_i,
  input  logic                                 bit_i,
  input  logic                                 test_byp_i,
  input  logic                                 cnt_rst_i,
  input  logic                                 clr_full_i,
  input  logic                                 clr_err_i,
  output logic [HOLD_W/WORD_W-1:0][WORD_W-1:0] words_o,
  output logic                                 full_o,
  output logic                                 busy_o,
  output logic                                 rep_err_o
);
  logic               take, flush, grp_done;
  logic [GROUP_W-1:0] grp;
  verdict_e           verdict;

  assign take   = src_en_i && bit_vld_i && !full_o;
  assign flush  = cnt_rst_i && !src_en_i;
  assign busy_o = src_en_i && !full_o;

  ec_group_packer #(.GROUP_W(GROUP_W)) u_packer (
    .clk_i(clk_i), .rst_ni(rst_ni), .take_i(take), .bit_i(bit_i),
    .flush_i(flush), .done_o(grp_done), .grp_o(grp)
  );

  ec_rep_tester #(.GROUP_W(GROUP_W)) u_tester (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(grp_done), .grp_i(grp),
    .bypass_i(test_byp_i), .clr_err_i(clr_err_i),
    .verdict_o(verdict), .err_o(rep_err_o)
  );

  ec_hold_reg #(.HOLD_W(HOLD_W), .GROUP_W(GROUP_W), .WORD_W(WORD_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .store_i(verdict == VERD_PASS),
    .grp_i(grp), .flush_i(flush), .clr_full_i(clr_full_i),
    .words_o(words_o), .full_o(full_o)
  );

  p_cnt_rst_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_en_i && full_o && !clr_full_i) |=> full_o);
  p_cnt_rst_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_rst_i && !src_en_i) |=> !full_o);
endmodule

// File: tb/tb_entropy_collector.sv
module tb_entropy_collector;
  localparam int HOLD_W = 192;
  localparam int NW = 6;

  logic clk = 0, rst_n = 0;
  logic src_en = 0, bit_vld = 0, bit_d = 0, byp = 0, cnt_rst = 0, clr_full = 0, clr_err = 0;
  logic [NW-1:0][31:0] words;
  logic full, busy, err;

  int n_checks = 0, n_fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  entropy_collector dut (
    .clk_i(clk), .rst_ni(rst_n), .src_en_i(src_en), .bit_vld_i(bit_vld), .bit_i(bit_d),
    .test_byp_i(byp), .cnt_rst_i(cnt_rst), .clr_full_i(clr_full), .clr_err_i(clr_err),
    .words_o(words), .full_o(full), .busy_o(busy), .rep_err_o(err)
  );

  // behavioural reference model
  bit          mq[$];
  logic [15:0] m_ref;
  bit          m_ref_ok;
  int          m_slot;
  logic [HOLD_W-1:0] m_hold;
  bit          m_full, m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete(); m_ref = '0; m_ref_ok = 0; m_slot = 0; m_hold = '0; m_full = 0; m_err = 0;
    end else begin
      bit take, fail, store;
      logic [15:0] g;
      take = src_en && bit_vld && !m_full;
      fail = 0; store = 0; g = '0;
      if (!src_en && cnt_rst) begin
        mq.delete(); m_slot = 0; m_full = 0;
      end else if (take) begin
        mq.push_back(bit_d);
        if (mq.size() == 16) begin
          for (int i = 0; i < 16; i++) g[i] = mq[i];
          mq.delete();
          if (!byp && m_ref_ok && g == m_ref) begin
            fail = 1; m_ref_ok = 0;
          end else begin
            store = 1; m_ref = g; m_ref_ok = 1;
          end
        end
      end
      if (store) begin
        m_hold[m_slot*16 +: 16] = g;
        if (m_slot == 11) begin m_slot = 0; m_full = 1; end
        else m_slot++;
      end else if (clr_full && !(!src_en && cnt_rst)) m_full = 0;
      if (fail) m_err = 1;
      else if (clr_err) m_err = 0;
    end
  end

  task automatic chk(string req, string what, logic [HOLD_W-1:0] got, logic [HOLD_W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R2", "words vs model", words, m_hold);
      chk("R1", "full vs model", full, m_full);
      chk("R3", "err vs model", err, m_err);
      chk("R8", "busy vs model", busy, src_en && !m_full);
    end
  end

  task automatic send_bit(bit b);
    bit_vld = 1; bit_d = b;
    @(negedge clk);
    bit_vld = 0;
  endtask

  task automatic send_grp(logic [15:0] g);
    for (int i = 0; i < 16; i++) send_bit(g[i]);
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [HOLD_W-1:0] snap;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "words at reset", words, '0);
    chk("R9", "full at reset", full, 0);
    chk("R9", "err at reset", err, 0);
    chk("R8", "busy with source off", busy, 0);
    rst_n = 1;
    @(negedge clk);
    src_en = 1; #1;
    chk("R8", "busy when enabled", busy, 1);
    @(negedge clk);

    // R1/R2 first fill
    for (int k = 0; k < 12; k++) send_grp(16'h1000 + 16'(k) * 16'h0111);
    chk("R1", "full after 192 bits", full, 1);
    chk("R2", "word0", words[0], {16'h1111, 16'h1000});
    chk("R2", "word5", words[5], {16'h1BBB, 16'h1AAA});
    chk("R8", "busy when full", busy, 0);

    // R8 bits ignored while full
    snap = words;
    send_grp(16'hFFFF);
    chk("R8", "words unchanged while full", words, snap);

    // R7 clear full
    pulse(clr_full);
    chk("R7", "full cleared", full, 0);

    // R3 repeat of reference 0x1BBB is discarded
    send_grp(16'h1BBB);
    chk("R3", "err after repeat", err, 1);
    chk("R3", "failing group not stored", words[0][15:0], 16'h1000);
    // R4 next group accepted unconditionally
    send_grp(16'h1BBB);
    chk("R4", "group after failure stored", words[0][15:0], 16'h1BBB);
    pulse(clr_err);
    chk("R7", "err cleared", err, 0);

    // R5 bypass
    byp = 1;
    send_grp(16'h1BBB);
    byp = 0;
    chk("R5", "no err under bypass", err, 0);
    chk("R5", "bypassed group stored", words[0][31:16], 16'h1BBB);

    // finish second fill (slots 2..11)
    for (int k = 0; k < 10; k++) send_grp(16'h2000 + 16'(k) * 16'h0123);
    chk("R1", "full after refill", full, 1);

    // R6 ignored with source on
    pulse(cnt_rst);
    chk("R6", "cnt reset ignored while enabled", full, 1);
    src_en = 0;
    pulse(cnt_rst);
    chk("R6", "cnt reset clears full", full, 0);

    // R8 bits ignored with source off
    snap = words;
    send_grp(16'h5555);
    chk("R8", "words unchanged with source off", words, snap);

    // R6 partial group discarded
    src_en = 1;
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    src_en = 0;
    pulse(cnt_rst);
    src_en = 1;
    send_grp(16'h3C5A);
    chk("R6", "slot0 after partial discard", words[0][15:0], 16'h3C5A);

    // R7 failure wins over simultaneous clear
    clr_err = 1;
    send_grp(16'h3C5A);
    clr_err = 0;
    chk("R7", "fail beats clear", err, 1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule